// File: doc/BRIEF.md
# Directory Slice Home Controller

This block is the home node for one slice of a block-level coherence directory in an eight-core system. It owns a fixed group of block addresses and keeps, for each block, a record of which private caches hold a valid copy and whether one of them holds a modified copy. Cores send it read, write and writeback requests. It answers them with targeted messages rather than a broadcast: data replies, ownership grants, invalidations of other holders and forwards to the current owner.

Every invalidate or forward the slice sends must be acknowledged by the target core before the transaction can finish. An acknowledgement from a modified owner carries that owner's block data, and the slice writes it to the backing store. The slice runs one transaction at a time. While a transaction is open it holds the request channel not-ready. At the end of each transaction it reports the block's new directory entry for one cycle. A small word-per-block store stands in for main memory.

Top module: `dir_slice`

## Requirements
- R1: After reset, `req_ready` is high, `msg_valid` and `cmp_valid` are low, every block has no holders and is clean, and the memory word of block index i holds the value i.
- R2: A request whose upper address bits (above the block index) differ from `SLICE_SEL` is accepted and then dropped. It produces no message and no completion, and it leaves the entry and memory unchanged.
- R3: A read of a clean block produces a data message (kind 0) to the requester carrying the memory word. It then sets the requester's holder bit, and the dirty bit stays 0.
- R4: A read of a dirty block held by another core first sends a forward (kind 2) to that owner. Once the owner acknowledges, the owner's data is written to memory, a data message (kind 0) carrying it goes to the requester, dirty is cleared, and both cores' holder bits are set.
- R5: A write (op 1) sends an invalidate (kind 1) to every holder except the requester, one per cycle in ascending core order. After all acknowledgements, it sends a grant (kind 3) carrying the memory word, and the entry holds only the requester's bit with dirty set. If there are no other holders, the grant is sent with no invalidates.
- R6: When a write invalidates a modified owner, the owner's acknowledgement data reaches memory before the grant, and the grant carries that data. Acknowledgement data from clean holders is never written.
- R7: A writeback (op 2) from the owner of a dirty block stores its data, clears its holder bit and the dirty bit, and sends no message. A writeback from any other core leaves the entry and memory unchanged.
- R8: `req_ready` is low from the cycle after a home request is accepted until the completion cycle. Only one transaction is open at a time.
- R9: An acknowledgement from a core that has no outstanding invalidate or forward is ignored. A transaction never finishes while an acknowledgement is still owed, and the owed count never goes below zero.
- R10: Each home transaction ends with a one-cycle `cmp_valid` reporting the entry's new holder vector and dirty bit. In that same cycle `req_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slice can take a request |
| req_op | input | 2 | 0 read, 1 write, 2 writeback |
| req_core | input | 3 | Requesting core |
| req_addr | input | 6 | Block address: slice select above, block index in low 4 bits |
| req_data | input | 32 | Writeback data |
| msg_valid | output | 1 | Outgoing message present |
| msg_kind | output | 2 | 0 data, 1 invalidate, 2 forward, 3 grant |
| msg_core | output | 3 | Destination core |
| msg_addr | output | 6 | Block address of the message |
| msg_data | output | 32 | Block data for kinds 0 and 3, zero otherwise |
| ack_valid | input | 1 | Acknowledgement present |
| ack_core | input | 3 | Acknowledging core |
| ack_data | input | 32 | Owner's block data, meaningful from a modified owner |
| cmp_valid | output | 1 | Transaction finished this cycle |
| cmp_presence | output | 8 | New holder vector of the block |
| cmp_dirty | output | 1 | New dirty bit of the block |

## Verification
The hardest situation to reach is an acknowledgement that arrives while invalidates are still being sent. It is hardest when that acknowledgement carries a modified owner's data or comes from a core that was never asked. The bench's cache models answer after a delay that depends on the core index, so acknowledgements arrive out of order and overlap the invalidate train. After a request is accepted, the bench places a stray acknowledgement from an uninvolved core carrying junk data, so that a wrongly accepted one shows up as a wrong grant word or an early completion. A reference model of holders, dirty bits, memory and per-core cached data predicts every message and completion.

// File: rtl/dir_pkg.sv
package dir_pkg;

   typedef enum logic [1:0] {
      OP_READ   = 2'd0,
      OP_WRITE  = 2'd1,
      OP_WRBACK = 2'd2,
      OP_NONE   = 2'd3
   } req_op_e;

   typedef enum logic [1:0] {
      MSG_DATA  = 2'd0,
      MSG_INV   = 2'd1,
      MSG_FWD   = 2'd2,
      MSG_GRANT = 2'd3
   } msg_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_DECIDE = 2'd1,
      ST_XFER   = 2'd2
   } ctl_state_e;

endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store #(
   parameter int NUM_CORES   = 8,
   parameter int NUM_ENTRIES = 16,
   parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [NUM_CORES-1:0] rd_pres,
   output logic                 rd_dirty,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [NUM_CORES-1:0] wr_pres,
   input  logic                 wr_dirty
);

   logic [NUM_CORES-1:0] pres_q  [NUM_ENTRIES];
   logic                 dirty_q [NUM_ENTRIES];

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pres_q[g]  <= '0;
            dirty_q[g] <= 1'b0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            pres_q[g]  <= wr_pres;
            dirty_q[g] <= wr_dirty;
         end
      end
   end

   assign rd_pres  = pres_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];

   // R5
   dirty_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_dirty) |-> ($countones(wr_pres) == 1));

endmodule

// File: rtl/dir_mem_stub.sv
module dir_mem_stub #(
   parameter int DATA_W      = 32,
   parameter int NUM_ENTRIES = 16,
   parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data
);

   logic [DATA_W-1:0] word_q [NUM_ENTRIES];

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q[g] <= DATA_W'(g);
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            word_q[g] <= wr_data;
         end
      end
   end

   assign rd_data = word_q[rd_idx];

endmodule

// File: rtl/dir_ack_tracker.sv
module dir_ack_tracker #(
   parameter int NUM_CORES = 8,
   parameter int CORE_W    = $clog2(NUM_CORES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [NUM_CORES-1:0] load_mask,
   input  logic                 ack_valid,
   input  logic [CORE_W-1:0]    ack_core,
   output logic                 send_valid,
   output logic [CORE_W-1:0]    send_core,
   output logic                 ack_take,
   output logic                 all_done
);

   localparam int CNT_W = $clog2(NUM_CORES + 1);

   logic [NUM_CORES-1:0] send_q;
   logic [NUM_CORES-1:0] pend_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [NUM_CORES-1:0] ack_hot;

   function automatic logic [CORE_W-1:0] lowest_idx(input logic [NUM_CORES-1:0] m);
      lowest_idx = '0;
      for (int i = NUM_CORES - 1; i >= 0; i--) begin
         if (m[i]) lowest_idx = i[CORE_W-1:0];
      end
   endfunction

   function automatic logic [CNT_W-1:0] pop_count(input logic [NUM_CORES-1:0] m);
      pop_count = '0;
      for (int i = 0; i < NUM_CORES; i++) begin
         pop_count = pop_count + CNT_W'(m[i]);
      end
   endfunction

   assign ack_hot    = NUM_CORES'(1) << ack_core;
   assign send_valid = (send_q != '0);
   assign send_core  = lowest_idx(send_q);
   assign ack_take   = ack_valid && ((ack_hot & pend_q & ~send_q) != '0);
   assign all_done   = (send_q == '0) && (pend_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         send_q <= '0;
         pend_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         send_q <= load_mask;
         pend_q <= load_mask;
         cnt_q  <= pop_count(load_mask);
      end else begin
         if (send_valid) send_q <= send_q & (send_q - 1'b1);
         if (ack_take) begin
            pend_q <= pend_q & ~ack_hot;
            cnt_q  <= cnt_q - 1'b1;
         end
      end
   end

   // R9
   ack_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take |-> (cnt_q != '0));

   // R9
   ack_count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (cnt_q == CNT_W'($countones(pend_q))));

endmodule

// File: rtl/dir_slice.sv
module dir_slice
   import dir_pkg::*;
#(
   parameter  int NUM_CORES   = 8,
   parameter  int NUM_ENTRIES = 16,
   parameter  int DATA_W      = 32,
   parameter  int SEL_W       = 2,
   parameter  int SLICE_SEL   = 1,
   localparam int CORE_W      = $clog2(NUM_CORES),
   localparam int IDX_W       = $clog2(NUM_ENTRIES),
   localparam int ADDR_W      = SEL_W + IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [1:0]           req_op,
   input  logic [CORE_W-1:0]    req_core,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_data,
   output logic                 msg_valid,
   output logic [1:0]           msg_kind,
   output logic [CORE_W-1:0]    msg_core,
   output logic [ADDR_W-1:0]    msg_addr,
   output logic [DATA_W-1:0]    msg_data,
   input  logic                 ack_valid,
   input  logic [CORE_W-1:0]    ack_core,
   input  logic [DATA_W-1:0]    ack_data,
   output logic                 cmp_valid,
   output logic [NUM_CORES-1:0] cmp_presence,
   output logic                 cmp_dirty
);

   initial begin
      assert (NUM_CORES >= 2) else $error("slice needs at least two cores");
      assert (NUM_ENTRIES == (1 << IDX_W)) else $error("entry count must be a power of two");
      assert (IDX_W >= 1) else $error("slice needs at least two entries");
      assert (SEL_W >= 0 && SEL_W < 16) else $error("select width out of range");
      assert (SLICE_SEL >= 0 && SLICE_SEL < (1 << SEL_W)) else $error("slice select does not fit");
      assert (DATA_W >= 8) else $error("data word too narrow");
   end

   // home decode: variant chosen by whether any select bits exist
   logic home_hit;
   if (SEL_W > 0) begin : g_sel
      assign home_hit = (req_addr[ADDR_W-1:IDX_W] == SLICE_SEL[SEL_W-1:0]);
   end else begin : g_nosel
      assign home_hit = 1'b1;
   end

   ctl_state_e          st_q, st_n;
   req_op_e             op_q;
   logic [CORE_W-1:0]   core_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   data_q;
   logic [IDX_W-1:0]    idx;

   logic [NUM_CORES-1:0] rd_pres;
   logic                 rd_dirty;
   logic [DATA_W-1:0]    mem_rdata;

   logic                 ent_we;
   logic [NUM_CORES-1:0] ent_pres_n;
   logic                 ent_dirty_n;
   logic                 mem_we;
   logic [DATA_W-1:0]    mem_wdata;

   logic                 trk_load;
   logic [NUM_CORES-1:0] trk_mask;
   logic                 trk_send;
   logic [CORE_W-1:0]    trk_core;
   logic                 trk_take;
   logic                 trk_done;

   logic                 msg_v_n;
   msg_kind_e            msg_k_n;
   logic [CORE_W-1:0]    msg_c_n;
   logic [DATA_W-1:0]    msg_d_n;
   logic                 cmp_v_n;

   logic [NUM_CORES-1:0] req_bit;
   logic [NUM_CORES-1:0] others;
   logic                 held_by_req;

   assign idx         = addr_q[IDX_W-1:0];
   assign req_bit     = NUM_CORES'(1) << core_q;
   assign others      = rd_pres & ~req_bit;
   assign held_by_req = ((rd_pres & req_bit) != '0);
   assign req_ready   = (st_q == ST_IDLE);

   dir_entry_store #(
      .NUM_CORES   (NUM_CORES),
      .NUM_ENTRIES (NUM_ENTRIES),
      .IDX_W       (IDX_W)
   ) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (idx),
      .rd_pres  (rd_pres),
      .rd_dirty (rd_dirty),
      .wr_en    (ent_we),
      .wr_idx   (idx),
      .wr_pres  (ent_pres_n),
      .wr_dirty (ent_dirty_n)
   );

   dir_mem_stub #(
      .DATA_W      (DATA_W),
      .NUM_ENTRIES (NUM_ENTRIES),
      .IDX_W       (IDX_W)
   ) i_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (idx),
      .rd_data (mem_rdata),
      .wr_en   (mem_we),
      .wr_idx  (idx),
      .wr_data (mem_wdata)
   );

   dir_ack_tracker #(
      .NUM_CORES (NUM_CORES),
      .CORE_W    (CORE_W)
   ) i_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (trk_load),
      .load_mask  (trk_mask),
      .ack_valid  (ack_valid),
      .ack_core   (ack_core),
      .send_valid (trk_send),
      .send_core  (trk_core),
      .ack_take   (trk_take),
      .all_done   (trk_done)
   );

   always_comb begin
      st_n        = st_q;
      ent_we      = 1'b0;
      ent_pres_n  = rd_pres;
      ent_dirty_n = rd_dirty;
      mem_we      = 1'b0;
      mem_wdata   = data_q;
      trk_load    = 1'b0;
      trk_mask    = '0;
      msg_v_n     = 1'b0;
      msg_k_n     = MSG_DATA;
      msg_c_n     = core_q;
      msg_d_n     = '0;
      cmp_v_n     = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_valid && home_hit) st_n = ST_DECIDE;
         end
         ST_DECIDE: begin
            unique case (op_q)
               OP_READ: begin
                  if (rd_dirty && !held_by_req) begin
                     trk_load = 1'b1;
                     trk_mask = rd_pres;
                     st_n     = ST_XFER;
                  end else begin
                     msg_v_n    = 1'b1;
                     msg_k_n    = MSG_DATA;
                     msg_d_n    = mem_rdata;
                     ent_we     = 1'b1;
                     ent_pres_n = rd_pres | req_bit;
                     cmp_v_n    = 1'b1;
                     st_n       = ST_IDLE;
                  end
               end
               OP_WRITE: begin
                  if (others == '0) begin
                     msg_v_n     = 1'b1;
                     msg_k_n     = MSG_GRANT;
                     msg_d_n     = mem_rdata;
                     ent_we      = 1'b1;
                     ent_pres_n  = req_bit;
                     ent_dirty_n = 1'b1;
                     cmp_v_n     = 1'b1;
                     st_n        = ST_IDLE;
                  end else begin
                     trk_load = 1'b1;
                     trk_mask = others;
                     st_n     = ST_XFER;
                  end
               end
               OP_WRBACK: begin
                  if (rd_dirty && held_by_req) begin
                     mem_we      = 1'b1;
                     mem_wdata   = data_q;
                     ent_we      = 1'b1;
                     ent_pres_n  = others;
                     ent_dirty_n = 1'b0;
                  end
                  cmp_v_n = 1'b1;
                  st_n    = ST_IDLE;
               end
               default: begin
                  cmp_v_n = 1'b1;
                  st_n    = ST_IDLE;
               end
            endcase
         end
         ST_XFER: begin
            if (trk_send) begin
               msg_v_n = 1'b1;
               msg_k_n = (op_q == OP_READ) ? MSG_FWD : MSG_INV;
               msg_c_n = trk_core;
            end
            if (trk_take && rd_dirty) begin
               mem_we    = 1'b1;
               mem_wdata = ack_data;
            end
            if (trk_done) begin
               msg_v_n = 1'b1;
               msg_c_n = core_q;
               msg_d_n = mem_rdata;
               ent_we  = 1'b1;
               cmp_v_n = 1'b1;
               st_n    = ST_IDLE;
               if (op_q == OP_READ) begin
                  msg_k_n     = MSG_DATA;
                  ent_pres_n  = rd_pres | req_bit;
                  ent_dirty_n = 1'b0;
               end else begin
                  msg_k_n     = MSG_GRANT;
                  ent_pres_n  = req_bit;
                  ent_dirty_n = 1'b1;
               end
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         op_q         <= OP_NONE;
         core_q       <= '0;
         addr_q       <= '0;
         data_q       <= '0;
         msg_valid    <= 1'b0;
         msg_kind     <= 2'd0;
         msg_core     <= '0;
         msg_addr     <= '0;
         msg_data     <= '0;
         cmp_valid    <= 1'b0;
         cmp_presence <= '0;
         cmp_dirty    <= 1'b0;
      end else begin
         st_q <= st_n;
         if (st_q == ST_IDLE && req_valid) begin
            op_q   <= req_op_e'(req_op);
            core_q <= req_core;
            addr_q <= req_addr;
            data_q <= req_data;
         end
         msg_valid    <= msg_v_n;
         msg_kind     <= msg_k_n;
         msg_core     <= msg_c_n;
         msg_addr     <= addr_q;
         msg_data     <= msg_d_n;
         cmp_valid    <= cmp_v_n;
         cmp_presence <= ent_pres_n;
         cmp_dirty    <= ent_dirty_n;
      end
   end

   // R8
   busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && home_hit) |=> !req_ready);

   // R10
   cmp_frees_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |-> req_ready);

   // R5
   grant_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && cmp_dirty) |-> ($countones(cmp_presence) == 1));

   // R2
   foreign_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !home_hit) |=> (!msg_valid && !cmp_valid && req_ready));

   // R9
   no_early_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_XFER && !trk_done) |=> !cmp_valid);

endmodule

// File: tb/test_dir_slice.sv
`timescale 1ns/1ps
module test_dir_slice;

   localparam int NC = 8, NE = 16, DW = 32, SW = 2, SSEL = 1, CW = 3, IW = 4, AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = '0;
   logic [CW-1:0] req_core = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          msg_valid;
   logic [1:0]    msg_kind;
   logic [CW-1:0] msg_core;
   logic [AW-1:0] msg_addr;
   logic [DW-1:0] msg_data;
   logic          ack_valid = 1'b0;
   logic [CW-1:0] ack_core = '0;
   logic [DW-1:0] ack_data = '0;
   logic          cmp_valid;
   logic [NC-1:0] cmp_presence;
   logic          cmp_dirty;

   dir_slice #(.NUM_CORES(NC), .NUM_ENTRIES(NE), .DATA_W(DW), .SEL_W(SW), .SLICE_SEL(SSEL)) i_dir_slice (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_core(req_core), .req_addr(req_addr), .req_data(req_data), .msg_valid(msg_valid),
      .msg_kind(msg_kind), .msg_core(msg_core), .msg_addr(msg_addr), .msg_data(msg_data),
      .ack_valid(ack_valid), .ack_core(ack_core), .ack_data(ack_data), .cmp_valid(cmp_valid),
      .cmp_presence(cmp_presence), .cmp_dirty(cmp_dirty));

   always #2.5 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit busy = 1'b0;
   bit done = 1'b0;

   // expected messages and completions
   int            ek[$];
   int            ec[$];
   int            ea[$];
   logic [DW-1:0] ed[$];
   string         et[$];
   logic [NC-1:0] xp[$];
   bit            xd[$];
   string         xt[$];
   // acknowledgement queue for the cache models
   int            aq_core[$];
   logic [DW-1:0] aq_data[$];
   int            aq_due[$];

   // reference model
   logic [NC-1:0] m_pres [NE];
   bit            m_dirty [NE];
   logic [DW-1:0] m_mem [NE];
   logic [DW-1:0] c_data [NC][NE];
   bit            c_own [NC][NE];

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic push_msg(int k, int c, int a, logic [DW-1:0] d, string t);
      ek.push_back(k); ec.push_back(c); ea.push_back(a); ed.push_back(d); et.push_back(t);
   endtask

   function automatic int lowest(logic [NC-1:0] m);
      for (int i = 0; i < NC; i++) if (m[i]) return i;
      return -1;
   endfunction

   // monitor and reference comparison, away from the active edge
   always @(negedge clk) begin
      int k, c, a, ci, ix;
      logic [DW-1:0] d;
      string t;
      logic [NC-1:0] p;
      bit dy;
      cyc++;
      if (rst_n) begin
         if (msg_valid) begin
            ix = int'(msg_addr[IW-1:0]);
            ci = int'(msg_core);
            if (ek.size() == 0) begin
               check(1'b0, "R2", "unexpected message kind", 64'(msg_kind), 64'hF);
            end else begin
               k = ek.pop_front(); c = ec.pop_front(); a = ea.pop_front();
               d = ed.pop_front(); t = et.pop_front();
               check(int'(msg_kind) == k, t, "message kind", 64'(msg_kind), 64'(k));
               check(ci == c, t, "message core", 64'(msg_core), 64'(c));
               check(int'(msg_addr) == a, t, "message address", 64'(msg_addr), 64'(a));
               if (k == 0 || k == 3)
                  check(msg_data == d, t, "message data", 64'(msg_data), 64'(d));
            end
            if (msg_kind == 2'd1 || msg_kind == 2'd2) begin
               aq_core.push_back(ci);
               aq_data.push_back(c_own[ci][ix] ? c_data[ci][ix] : (32'hDEAD_0000 | DW'(ci)));
               aq_due.push_back(cyc + 1 + (ci % 3));
               c_own[ci][ix] = 1'b0;
            end
            if (msg_kind == 2'd3) c_own[ci][ix] = 1'b1;
         end
         if (cmp_valid) begin
            if (xp.size() == 0) begin
               check(1'b0, "R2", "unexpected completion", 64'(cmp_presence), 64'h0);
            end else begin
               p = xp.pop_front(); dy = xd.pop_front(); t = xt.pop_front();
               check(cmp_presence == p, t, "R10 holder vector", 64'(cmp_presence), 64'(p));
               check(cmp_dirty == dy, t, "R10 dirty bit", 64'(cmp_dirty), 64'(dy));
            end
            busy = 1'b0;
         end
         check(req_ready == !busy, "R8", "req_ready", 64'(req_ready), 64'(!busy));
      end
   end

   // cache-side acknowledgement driver
   always @(posedge clk) begin
      #1;
      if (aq_due.size() > 0 && aq_due[0] <= cyc) begin
         ack_valid = 1'b1;
         ack_core  = CW'(aq_core.pop_front());
         ack_data  = aq_data.pop_front();
         void'(aq_due.pop_front());
      end else begin
         ack_valid = 1'b0;
      end
   end

   // op: 0 read, 1 write, 2 writeback
   task automatic issue(int op, int core, int idx, logic [DW-1:0] data, bit home, string tag, int stray);
      logic [NC-1:0] bm, tgt;
      int owner, a;
      bm = NC'(1) << core;
      a  = home ? ((SSEL << IW) | idx) : (((SSEL + 1) % 4 << IW) | idx);
      if (home) begin
         if (op == 0) begin
            if (m_dirty[idx] && (m_pres[idx] & bm) == '0) begin
               owner = lowest(m_pres[idx]);
               push_msg(2, owner, a, '0, tag);
               m_mem[idx] = c_data[owner][idx];
               m_dirty[idx] = 1'b0;
            end
            push_msg(0, core, a, m_mem[idx], tag);
            m_pres[idx] |= bm;
            c_data[core][idx] = m_mem[idx];
         end else if (op == 1) begin
            tgt = m_pres[idx] & ~bm;
            for (int i = 0; i < NC; i++) if (tgt[i]) push_msg(1, i, a, '0, tag);
            if (m_dirty[idx] && tgt != '0) m_mem[idx] = c_data[lowest(m_pres[idx])][idx];
            push_msg(3, core, a, m_mem[idx], tag);
            m_pres[idx] = bm;
            m_dirty[idx] = 1'b1;
            c_data[core][idx] = data;
         end else begin
            if (m_dirty[idx] && (m_pres[idx] & bm) != '0) begin
               m_mem[idx] = data;
               m_pres[idx] &= ~bm;
               m_dirty[idx] = 1'b0;
               c_own[core][idx] = 1'b0;
            end
         end
         xp.push_back(m_pres[idx]); xd.push_back(m_dirty[idx]); xt.push_back(tag);
      end
      @(posedge clk); #1;
      while (!req_ready) begin @(posedge clk); #1; end
      req_op = 2'(op); req_core = CW'(core); req_addr = AW'(a); req_data = data;
      req_valid = 1'b1;
      @(posedge clk);
      if (home) busy = 1'b1;
      #1 req_valid = 1'b0;
      if (stray >= 0) begin
         aq_core.push_front(stray); aq_data.push_front(32'hBAD0_0000); aq_due.push_front(0);
      end
      if (home) begin
         while (busy) @(negedge clk);
      end else begin
         repeat (4) @(negedge clk);
      end
      repeat (2) @(negedge clk);
      check(ek.size() == 0, tag, "messages still expected", 64'(ek.size()), 64'h0);
      check(aq_due.size() == 0, "R9", "acknowledgements left outstanding", 64'(aq_due.size()), 64'h0);
   endtask

   initial begin
      for (int i = 0; i < NE; i++) begin
         m_pres[i] = '0; m_dirty[i] = 1'b0; m_mem[i] = DW'(i);
         for (int c = 0; c < NC; c++) begin c_data[c][i] = '0; c_own[c][i] = 1'b0; end
      end
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'h1);
      check(msg_valid == 1'b0, "R1", "message after reset", 64'(msg_valid), 64'h0);
      check(cmp_valid == 1'b0, "R1", "completion after reset", 64'(cmp_valid), 64'h0);
      // R1: reset memory contents, R3: clean reads
      issue(0, 0, 3, '0, 1'b1, "R1", -1);
      issue(0, 1, 5, '0, 1'b1, "R3", -1);
      issue(0, 2, 5, '0, 1'b1, "R3", -1);
      issue(0, 4, 5, '0, 1'b1, "R3", -1);
      // R5: write invalidates the other holders
      issue(1, 2, 5, 32'hA000_0005, 1'b1, "R5", -1);
      // R4: read of a dirty block goes through the owner
      issue(0, 6, 5, '0, 1'b1, "R4", -1);
      // R6: clean acknowledgement data is not stored
      issue(1, 0, 5, 32'hB000_0005, 1'b1, "R6", -1);
      // R6: modified owner's data reaches the grant
      issue(1, 3, 5, 32'hC000_0005, 1'b1, "R6", -1);
      // R7: writeback from a non-owner, then from the owner
      issue(2, 5, 5, 32'h1111_1111, 1'b1, "R7", -1);
      issue(2, 3, 5, 32'hD000_0005, 1'b1, "R7", -1);
      issue(0, 7, 5, '0, 1'b1, "R7", -1);
      // R2: foreign address dropped, then state observed unchanged
      issue(1, 1, 5, 32'hEEEE_EEEE, 1'b0, "R2", -1);
      issue(0, 1, 5, '0, 1'b1, "R2", -1);
      // R9: stray acknowledgements while invalidating a modified owner
      issue(0, 1, 9, '0, 1'b1, "R3", -1);
      issue(1, 1, 9, 32'h9000_0001, 1'b1, "R5", -1);
      issue(1, 2, 9, 32'h9000_0002, 1'b1, "R9", 6);
      issue(0, 3, 9, '0, 1'b1, "R9", 5);
      // R5: no other holders, grant at once
      issue(1, 4, 12, 32'hC0C0_0012, 1'b1, "R5", -1);
      // R5: all cores share, last one writes
      for (int c = 0; c < NC; c++) issue(0, c, 0, '0, 1'b1, "R3", -1);
      issue(1, 7, 0, 32'h7777_0000, 1'b1, "R5", 7);
      issue(0, 0, 0, '0, 1'b1, "R4", -1);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      wait (cyc > 50000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R8 watchdog: actual %0d expected %0d", cyc, 50000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule